// File: doc/BRIEF.md
# Merged Trivial-Rotation Butterfly Stages for an 8-Point Transform

This block finishes an 8-point radix-2 decimation-in-frequency transform once the first stage, the only one with non-trivial rotations, has been computed elsewhere. It captures eight complex 12-bit first-stage results into a register bank. It then runs the two remaining butterfly stages back to back through one shared array of four butterflies. Between the two clocks, only the operand multiplexers change.

The two remaining stages need rotations of 0 or -90 degrees only. A -90 degree rotation is a swap of the real and imaginary parts plus one negation, so the block uses no multipliers. A two-state stage counter drives the operand and destination multiplexers. The bank contents are shown on the outputs at every cycle. A `done` pulse marks the cycle in which the final results first appear. Those results are in bit-reversed frequency order. All arithmetic wraps modulo 2^12.

Top module: `fft8_tail_stages`

## Requirements
- R1: While reset is asserted and in the first cycle after its release, all of `out_re`/`out_im` are zero and `done` is low.
- R2: A `start` seen at a clock edge while the block is idle captures all eight inputs. The next cycle shows them unchanged on the outputs. Element k of each bus sits at bits [12k+11:12k].
- R3: One edge after capture, each group of four (elements 4g..4g+3, written a0..a3) shows the first merged stage on the outputs. Element 0 is a0+a2, element 1 is a1+a3 and element 2 is a0-a2.
- R4: In that same cycle, element 3 of each group is (a1-a3) multiplied by -j. Its real part is the imaginary part of the difference, and its imaginary part is the negated real part of the difference.
- R5: Two edges after capture, each group holds its 4-point transform A[k] = sum over n of a_n·(-j)^(n·k). The values are placed in the order A0, A2, A1, A3 at elements 0, 1, 2, 3.
- R6: `done` is high for exactly one cycle, the first cycle in which the R5 results are on the outputs.
- R7: Every sum, difference and negation wraps modulo 4096 in two's complement, with no saturation.
- R8: A `start` during either of the two processing cycles is ignored, and the results are those of the captured frame.
- R9: Once finished, the outputs hold their values while `start` stays low, whatever the inputs do.
- R10: A `start` in the cycle where `done` is high is accepted, and a new frame begins without an idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture request, taken only when idle |
| in_re | input | 96 | Real parts of the eight first-stage results |
| in_im | input | 96 | Imaginary parts of the eight first-stage results |
| out_re | output | 96 | Real parts of the register bank |
| out_im | output | 96 | Imaginary parts of the register bank |
| done | output | 1 | One-cycle pulse when the final results appear |

## Verification
The hardest case to reach from the ports is a `start` that arrives while the shared array is busy with the other stage's routing. Such a `start` must not disturb the bank. To cover it, the driver keeps `start` high with changed inputs through both processing cycles and then expects the first frame's transform. A second hard case is a new `start` landing in the single `done` cycle. The driver chains two frames exactly there, and the scoreboard must see both transforms in sequence. Intermediate stage-2 values are compared as well, so a wrong -j sign cannot hide behind the final combination.

// File: rtl/fft8_tail_stages.sv
module fft8_tail_stages #(
  parameter int W = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [8*W-1:0] in_re,
  input  logic [8*W-1:0] in_im,
  output logic [8*W-1:0] out_re,
  output logic [8*W-1:0] out_im,
  output logic           done
);
  localparam int NPT = 8;
  localparam int NBF = NPT / 2;

  logic [1:0] phase;
  logic       done_q;
  logic       late;

  logic signed [W-1:0] br [NPT];
  logic signed [W-1:0] bi [NPT];
  logic signed [W-1:0] nr [NPT];
  logic signed [W-1:0] ni [NPT];

  logic signed [W-1:0] s_re [NBF];
  logic signed [W-1:0] s_im [NBF];
  logic signed [W-1:0] d_re [NBF];
  logic signed [W-1:0] d_im [NBF];

  assign late = (phase == 2'd2);
  assign done = done_q;

  for (genvar b = 0; b < NBF; b++) begin : g_bfly
    localparam int G  = (b / 2) * 4;
    localparam int J  = b % 2;
    localparam int P2 = G + J;
    localparam int Q2 = G + J + 2;
    localparam int P3 = G + 2 * J;
    localparam int Q3 = G + 2 * J + 1;
    logic signed [W-1:0] pr, pi, qr, qi, dr, di;
    logic rot;
    assign pr = late ? br[P3] : br[P2];
    assign pi = late ? bi[P3] : bi[P2];
    assign qr = late ? br[Q3] : br[Q2];
    assign qi = late ? bi[Q3] : bi[Q2];
    assign s_re[b] = pr + qr;
    assign s_im[b] = pi + qi;
    assign dr = pr - qr;
    assign di = pi - qi;
    assign rot = !late && (J == 1);
    assign d_re[b] = rot ? di : dr;
    assign d_im[b] = rot ? -dr : di;
  end

  always_comb begin
    for (int k = 0; k < NPT; k++) begin
      nr[k] = '0;
      ni[k] = '0;
    end
    for (int b = 0; b < NBF; b++) begin
      if (late) begin
        nr[(b/2)*4 + 2*(b%2)]     = s_re[b];
        ni[(b/2)*4 + 2*(b%2)]     = s_im[b];
        nr[(b/2)*4 + 2*(b%2) + 1] = d_re[b];
        ni[(b/2)*4 + 2*(b%2) + 1] = d_im[b];
      end else begin
        nr[(b/2)*4 + (b%2)]       = s_re[b];
        ni[(b/2)*4 + (b%2)]       = s_im[b];
        nr[(b/2)*4 + (b%2) + 2]   = d_re[b];
        ni[(b/2)*4 + (b%2) + 2]   = d_im[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 2'd0;
      done_q <= 1'b0;
      for (int k = 0; k < NPT; k++) begin
        br[k] <= '0;
        bi[k] <= '0;
      end
    end else begin
      done_q <= 1'b0;
      case (phase)
        2'd0: if (start) begin
          phase <= 2'd1;
          for (int k = 0; k < NPT; k++) begin
            br[k] <= in_re[k*W +: W];
            bi[k] <= in_im[k*W +: W];
          end
        end
        2'd1: begin
          phase <= 2'd2;
          for (int k = 0; k < NPT; k++) begin
            br[k] <= nr[k];
            bi[k] <= ni[k];
          end
        end
        2'd2: begin
          phase  <= 2'd0;
          done_q <= 1'b1;
          for (int k = 0; k < NPT; k++) begin
            br[k] <= nr[k];
            bi[k] <= ni[k];
          end
        end
        default: phase <= 2'd0;
      endcase
    end
  end

  for (genvar k = 0; k < NPT; k++) begin : g_out
    assign out_re[k*W +: W] = br[k];
    assign out_im[k*W +: W] = bi[k];
  end

  a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_done_after_late: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(phase) == 2'd2);
  a_r8_entry_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd1) |-> ($past(phase) == 2'd0 && $past(start)));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd0 && !start) |=> ($stable(out_re) && $stable(out_im)));
endmodule

// File: tb/tb_fft8_tail_stages.sv
module tb_fft8_tail_stages;
  localparam int W = 12;
  localparam int WD_LIMIT = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [8*W-1:0] in_re = '0, in_im = '0;
  logic [8*W-1:0] out_re, out_im;
  logic done;

  int n_tests = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [8*W-1:0] q_re [$];
  logic [8*W-1:0] q_im [$];
  logic [8*W-1:0] last_re, last_im;

  always #2 clk = ~clk;

  fft8_tail_stages #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .in_re(in_re), .in_im(in_im), .out_re(out_re), .out_im(out_im), .done(done));

  function automatic logic [8*W-1:0] pack(input int v[8]);
    logic [8*W-1:0] r;
    for (int k = 0; k < 8; k++) r[k*W +: W] = v[k][W-1:0];
    return r;
  endfunction

  function automatic void mulj(input int r, input int i, input int m, output int orr, output int oi);
    case (m % 4)
      0: begin orr = r;  oi = i;  end
      1: begin orr = i;  oi = -r; end
      2: begin orr = -r; oi = -i; end
      default: begin orr = -i; oi = r; end
    endcase
  endfunction

  function automatic void exp_final(input int r[8], input int i[8], output int er[8], output int ei[8]);
    int pos [4] = '{0, 2, 1, 3};
    for (int g = 0; g < 2; g++)
      for (int k = 0; k < 4; k++) begin
        int ar = 0, ai = 0;
        for (int n = 0; n < 4; n++) begin
          int tr, ti;
          mulj(r[4*g+n], i[4*g+n], n * k, tr, ti);
          ar += tr; ai += ti;
        end
        er[4*g + pos[k]] = ar;
        ei[4*g + pos[k]] = ai;
      end
  endfunction

  function automatic void exp_mid(input int r[8], input int i[8], output int er[8], output int ei[8]);
    for (int g = 0; g < 2; g++) begin
      int b = 4 * g;
      er[b]   = r[b] + r[b+2];   ei[b]   = i[b] + i[b+2];
      er[b+1] = r[b+1] + r[b+3]; ei[b+1] = i[b+1] + i[b+3];
      er[b+2] = r[b] - r[b+2];   ei[b+2] = i[b] - i[b+2];
      er[b+3] = i[b+1] - i[b+3]; ei[b+3] = -(r[b+1] - r[b+3]);
    end
  endfunction

  task automatic check_vec(input string tag, input logic [8*W-1:0] er, input logic [8*W-1:0] ei);
    n_tests++;
    if (out_re !== er || out_im !== ei) begin
      n_fail++;
      $display("FAIL %s actual re=%h im=%h expected re=%h im=%h", tag, out_re, out_im, er, ei);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic expv);
    n_tests++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, expv);
    end
  endtask

  // Driver: issues start at a negedge, checks capture and stage-2 view, pushes final expectation.
  task automatic frame(input int r[8], input int i[8], input bit hold);
    int fr[8], fi[8], mr[8], mi[8];
    exp_final(r, i, fr, fi);
    exp_mid(r, i, mr, mi);
    @(negedge clk);
    in_re = pack(r); in_im = pack(i); start = 1'b1;
    q_re.push_back(pack(fr)); q_im.push_back(pack(fi));
    last_re = pack(fr); last_im = pack(fi);
    @(negedge clk);
    check_vec("R2 capture", pack(r), pack(i));
    if (hold) begin in_re = ~in_re; in_im = in_im ^ 96'h5a5; start = 1'b1; end
    else start = 1'b0;
    @(negedge clk);
    check_vec("R3 R4 stage-2 view", pack(mr), pack(mi));
    if (hold) begin in_re = in_re + 96'd77; start = 1'b1; end
  endtask

  task automatic finish_idle();
    @(negedge clk);
    start = 1'b0;
    check_bit("R6 done high with results", done, 1'b1);
    @(negedge clk);
    check_bit("R6 done single cycle", done, 1'b0);
  endtask

  // Monitor: pops expected results whenever done is seen.
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_tests++;
      if (q_re.size() == 0) begin
        n_fail++;
        $display("FAIL R6 done with no frame pending actual=1 expected=0");
      end else begin
        logic [8*W-1:0] er, ei;
        er = q_re.pop_front(); ei = q_im.pop_front();
        if (out_re !== er || out_im !== ei) begin
          n_fail++;
          $display("FAIL R5 R7 R8 R10 final actual re=%h im=%h expected re=%h im=%h",
                   out_re, out_im, er, ei);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT) begin
      n_fail++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int ar[8], ai[8], br2[8], bi2[8];
    repeat (3) @(negedge clk);
    check_vec("R1 reset outputs", '0, '0);
    check_bit("R1 reset done", done, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check_vec("R1 after release", '0, '0);

    ar = '{1, 2, 3, 4, 5, 6, 7, 8};       ai = '{0, 0, 0, 0, 0, 0, 0, 0};
    frame(ar, ai, 1'b0); finish_idle();

    ar = '{10, -3, 7, 22, -100, 5, 0, 63}; ai = '{4, 9, -8, 1, 33, -7, 12, -50};
    frame(ar, ai, 1'b0); finish_idle();

    // R9: outputs hold while inputs wander with start low
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      in_re = in_re + 96'd1234567; in_im = ~in_im;
      check_vec("R9 hold after finish", last_re, last_im);
    end

    // R7: wraparound on sums
    ar = '{2047, 2047, 2047, 2047, -2048, -2048, -2048, -2048};
    ai = '{2047, -2048, 2047, -2048, 1000, 1000, -1000, 1500};
    frame(ar, ai, 1'b0); finish_idle();

    // R8: start held high through both processing cycles with other data
    ar = '{-5, 17, 300, -299, 64, -64, 128, 1}; ai = '{8, -8, 0, 255, -1, 2, -3, 4};
    frame(ar, ai, 1'b1); finish_idle();

    // R10: chained start in the done cycle
    ar  = '{100, 200, -300, 400, 11, 22, 33, 44};  ai  = '{-1, -2, -3, -4, 5, 6, 7, 8};
    br2 = '{-7, 0, 19, 1000, -1500, 3, 900, -2}; bi2 = '{50, 60, -70, 80, 0, 0, 1, -1};
    frame(ar, ai, 1'b0);
    frame(br2, bi2, 1'b0);
    finish_idle();

    for (int t = 0; t < 6; t++) begin
      for (int k = 0; k < 8; k++) begin
        ar[k] = int'($urandom_range(4095)) - 2048;
        ai[k] = int'($urandom_range(4095)) - 2048;
      end
      frame(ar, ai, 1'b0); finish_idle();
    end

    repeat (2) @(negedge clk);
    n_tests++;
    if (q_re.size() != 0) begin
      n_fail++;
      $display("FAIL R6 frames without done actual=%0d expected=0", q_re.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule